// File: doc/BRIEF.md
# Accumulator Random-Access Machine

This block is a small processor with one accumulator. It keeps a program counter, an instruction register and one memory that holds both instructions and data. Because the stored program and its data share that memory, a program can overwrite its own instructions and then run them. Each instruction goes through the same fixed sequence. The word at the program counter is fetched and the counter moves past it. The fetched word is then decoded and its operand read. Finally the instruction runs. This repeats until a halt instruction stops the machine.

There are eight operations: load from memory, load of a constant, store, add from memory, add of a constant, unconditional jump, jump when the accumulator is zero, and halt. Every operand is a direct address or a constant taken from the instruction word. There is no indirection. A backdoor port lets the environment fill memory before a run and read results after one. The accumulator and a halted flag are visible on the outputs.

Top module: `accMachine`

## Requirements
- R1: While `rstN` is low, `halted` is 0 and `accOut` is 0. After release, execution starts at address 0.
- R2: An instruction word carries the opcode in bits 14:12 and the operand in bits 11:0. Bit 15 has no effect. The opcode values are: halt 0, load 1, load-constant 2, store 3, add 4, add-constant 5, jump 6, jump-if-zero 7.
- R3: Each instruction takes exactly three cycles: fetch with a program-counter increment, decode with the operand read, then execute. The result of an instruction is visible on `accOut` after the third rising edge counted from the start of its fetch.
- R4: Load sets the accumulator to the memory word at the operand address. Load-constant sets it to the 12-bit operand, zero-extended.
- R5: Store writes the accumulator into the memory word at the operand address.
- R6: Add and add-constant add the memory word or the zero-extended operand to the accumulator, modulo 2^16.
- R7: Jump always loads the program counter with the operand. Jump-if-zero does so only when the accumulator is 0. Otherwise the next instruction follows in sequence.
- R8: Once a halt has executed, `halted` stays 1 until reset. After that point no further instruction is fetched or executed, so `accOut` and memory are left unchanged.
- R9: A word that a store writes into a program location runs as an instruction when execution later reaches that location.
- R10: With `bdEn` high, the backdoor owns the memory port. `bdWe` high writes `bdWrData` at `bdAddr`. Otherwise the word at `bdAddr` appears on `bdRdData` one cycle later.
- R11: Place load 0x100, add 0x101, add 0x102, store 0x103 at addresses 0 to 3. This program leaves the sum of the words at 0x100, 0x101 and 0x102 in 0x103.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| halted | output | 1 | High once a halt has executed |
| accOut | output | 16 | Current accumulator value |
| bdEn | input | 1 | Backdoor takes the memory port |
| bdWe | input | 1 | Backdoor write strobe |
| bdAddr | input | 12 | Backdoor address |
| bdWrData | input | 16 | Backdoor write data |
| bdRdData | output | 16 | Memory read data, one cycle after the address |

## Verification
Four programs exercise the machine, and a behavioural instruction-level model is compared against the outputs on every cycle.

- **Summation program.** Its operands overflow 16 bits. It tells a correct memory-operand path apart from one that drops the wrap, or that adds the instruction word instead of the data.
- **Countdown loop.** It uses jump-if-zero both taken and not taken, an unconditional back jump, and an add-constant word with bit 15 set. It separates the zero test from the sequencing and shows that the spare bit is ignored.
- **Self-modifying program.** It stores a load-constant word over a halt. This shows that stored words are fetched as code.
- **Early halt.** A halt is followed by a store and a load. It checks that nothing after the halt touches the accumulator or memory.

// File: rtl/accRamPkg.sv
package accRamPkg;

  typedef enum logic [2:0] {
    OP_HALT  = 3'd0,
    OP_LD    = 3'd1,
    OP_LDI   = 3'd2,
    OP_ST    = 3'd3,
    OP_ADD   = 3'd4,
    OP_ADDI  = 3'd5,
    OP_JUMP  = 3'd6,
    OP_JZERO = 3'd7
  } opcode_e;

  localparam int OPC_W = 3;

  typedef enum logic [1:0] {
    ADDR_PC      = 2'd0,
    ADDR_FETCHED = 2'd1,
    ADDR_IR      = 2'd2
  } addrSel_e;

  typedef enum logic [1:0] {
    ACC_MEM    = 2'd0,
    ACC_IMM    = 2'd1,
    ACC_ADDMEM = 2'd2,
    ACC_ADDIMM = 2'd3
  } accSel_e;

  typedef struct packed {
    logic     pcInc;
    logic     pcLoad;
    logic     irLoad;
    logic     accLoad;
    accSel_e  accSel;
    logic     memWrite;
    addrSel_e addrSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/accRamMem.sv
module accRamMem #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[addr] <= wrData;
    rdData <= store[addr];
  end
endmodule

// File: rtl/accRamCtrl.sv
module accRamCtrl
  import accRamPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  opcode_e     irOp,
  input  logic        accZero,
  output ctrlStrobe_t strobe,
  output logic        halted
);
  typedef enum logic [1:0] {
    ST_FETCH  = 2'd0,
    ST_DECODE = 2'd1,
    ST_EXEC   = 2'd2,
    ST_STOP   = 2'd3
  } phase_e;

  phase_e phase, phaseNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= ST_FETCH;
    else       phase <= phaseNext;
  end

  always_comb begin
    strobe    = '0;
    strobe.addrSel = ADDR_PC;
    strobe.accSel  = ACC_MEM;
    phaseNext = phase;
    unique case (phase)
      ST_FETCH: begin
        strobe.pcInc = 1'b1;
        phaseNext    = ST_DECODE;
      end
      ST_DECODE: begin
        strobe.irLoad  = 1'b1;
        strobe.addrSel = ADDR_FETCHED;
        phaseNext      = ST_EXEC;
      end
      ST_EXEC: begin
        phaseNext = ST_FETCH;
        unique case (irOp)
          OP_HALT:  phaseNext = ST_STOP;
          OP_LD:    begin strobe.accLoad = 1'b1; strobe.accSel = ACC_MEM;    end
          OP_LDI:   begin strobe.accLoad = 1'b1; strobe.accSel = ACC_IMM;    end
          OP_ADD:   begin strobe.accLoad = 1'b1; strobe.accSel = ACC_ADDMEM; end
          OP_ADDI:  begin strobe.accLoad = 1'b1; strobe.accSel = ACC_ADDIMM; end
          OP_ST:    begin strobe.memWrite = 1'b1; strobe.addrSel = ADDR_IR; end
          OP_JUMP:  strobe.pcLoad = 1'b1;
          OP_JZERO: strobe.pcLoad = accZero;
          default:  phaseNext = ST_STOP;
        endcase
      end
      default: phaseNext = ST_STOP;
    endcase
  end

  assign halted = (phase == ST_STOP);

  // R8: the machine never leaves the halted condition except through reset
  p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted)
    else $error("halted dropped without reset");

endmodule

// File: rtl/accRamDatapath.sv
module accRamDatapath
  import accRamPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              bdEn,
  input  logic              bdWe,
  input  logic [ADDR_W-1:0] bdAddr,
  input  logic [DATA_W-1:0] bdWrData,
  output logic [DATA_W-1:0] bdRdData,
  output opcode_e           irOp,
  output logic              accZero,
  output logic [DATA_W-1:0] acc
);
  localparam int INSTR_W = ADDR_W + OPC_W;

  logic [ADDR_W-1:0]  pc;
  logic [INSTR_W-1:0] ir;
  logic [DATA_W-1:0]  rdData;
  logic [ADDR_W-1:0]  memAddr;
  logic               memWe;
  logic [DATA_W-1:0]  memWrData;
  logic [ADDR_W-1:0]  irOperand;
  logic [DATA_W-1:0]  immExt;
  logic [DATA_W-1:0]  accNext;

  assign irOperand = ir[ADDR_W-1:0];
  assign irOp      = opcode_e'(ir[INSTR_W-1:ADDR_W]);
  assign immExt    = {{(DATA_W-ADDR_W){1'b0}}, irOperand};

  always_comb begin
    unique case (strobe.addrSel)
      ADDR_FETCHED: memAddr = rdData[ADDR_W-1:0];
      ADDR_IR:      memAddr = irOperand;
      default:      memAddr = pc;
    endcase
    memWe     = strobe.memWrite;
    memWrData = acc;
    if (bdEn) begin
      memAddr   = bdAddr;
      memWe     = bdWe;
      memWrData = bdWrData;
    end
  end

  accRamMem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uMem (
    .clk    (clk),
    .we     (memWe),
    .addr   (memAddr),
    .wrData (memWrData),
    .rdData (rdData)
  );

  assign bdRdData = rdData;

  always_comb begin
    unique case (strobe.accSel)
      ACC_IMM:    accNext = immExt;
      ACC_ADDMEM: accNext = acc + rdData;
      ACC_ADDIMM: accNext = acc + immExt;
      default:    accNext = rdData;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc  <= '0;
      ir  <= '0;
      acc <= '0;
    end else begin
      if (strobe.pcLoad)     pc <= irOperand;
      else if (strobe.pcInc) pc <= pc + 1'b1;
      if (strobe.irLoad)     ir <= rdData[INSTR_W-1:0];
      if (strobe.accLoad)    acc <= accNext;
    end
  end

  assign accZero = (acc == '0);

  // R3: a fetch strobe advances the program counter by exactly one word
  p_pc_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pcInc && !strobe.pcLoad) |=> (pc == $past(pc) + 1'b1))
    else $error("pc did not advance by one");

  // R3: the instruction register captures the word returned by memory
  p_ir_capture_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.irLoad |=> (ir == $past(rdData[INSTR_W-1:0])))
    else $error("ir did not capture fetched word");

  // R7: a conditional branch only loads the counter when the accumulator is zero
  p_jz_guard_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pcLoad && irOp == OP_JZERO) |-> accZero)
    else $error("conditional jump taken with nonzero accumulator");

  // R4: the accumulator moves only under a load strobe
  p_acc_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.accLoad |=> $stable(acc))
    else $error("accumulator changed without a load");

endmodule

// File: rtl/accMachine.sv
module accMachine
  import accRamPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  output logic              halted,
  output logic [DATA_W-1:0] accOut,
  input  logic              bdEn,
  input  logic              bdWe,
  input  logic [ADDR_W-1:0] bdAddr,
  input  logic [DATA_W-1:0] bdWrData,
  output logic [DATA_W-1:0] bdRdData
);
  ctrlStrobe_t strobe;
  opcode_e     irOp;
  logic        accZero;

  accRamCtrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .irOp    (irOp),
    .accZero (accZero),
    .strobe  (strobe),
    .halted  (halted)
  );

  accRamDatapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .bdEn     (bdEn),
    .bdWe     (bdWe),
    .bdAddr   (bdAddr),
    .bdWrData (bdWrData),
    .bdRdData (bdRdData),
    .irOp     (irOp),
    .accZero  (accZero),
    .acc      (accOut)
  );
endmodule

// File: tb/sim_accMachine.sv
module sim_accMachine;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        halted;
  logic [15:0] accOut;
  logic        bdEn = 1'b0;
  logic        bdWe = 1'b0;
  logic [11:0] bdAddr = '0;
  logic [15:0] bdWrData = '0;
  logic [15:0] bdRdData;

  int nChecks = 0;
  int nFail = 0;

  logic [15:0] mMem [4096];
  logic [11:0] mPc;
  logic [15:0] mAcc;
  logic        mHalt;

  always #10 clk = ~clk;

  accMachine u0 (
    .clk(clk), .rstN(rstN), .halted(halted), .accOut(accOut),
    .bdEn(bdEn), .bdWe(bdWe), .bdAddr(bdAddr), .bdWrData(bdWrData),
    .bdRdData(bdRdData)
  );

  function automatic logic [15:0] enc(input int op, input int operand);
    return 16'((op & 7) << 12) | 16'(operand & 12'hFFF);
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bdWrite(input int addr, input logic [15:0] data);
    @(negedge clk);
    bdEn = 1'b1; bdWe = 1'b1; bdAddr = 12'(addr); bdWrData = data;
    @(negedge clk);
    bdEn = 1'b0; bdWe = 1'b0;
    mMem[addr] = data;
  endtask

  task automatic bdRead(input int addr, output logic [15:0] data);
    @(negedge clk);
    bdEn = 1'b1; bdWe = 1'b0; bdAddr = 12'(addr);
    @(negedge clk);
    data = bdRdData;
    bdEn = 1'b0;
  endtask

  // behavioural instruction-level reference
  task automatic modelStep();
    logic [15:0] w;
    logic [11:0] opnd;
    w = mMem[mPc];
    mPc = mPc + 12'd1;
    opnd = w[11:0];
    case (w[14:12])
      3'd0: mHalt = 1'b1;
      3'd1: mAcc = mMem[opnd];
      3'd2: mAcc = {4'h0, opnd};
      3'd3: mMem[opnd] = mAcc;
      3'd4: mAcc = mAcc + mMem[opnd];
      3'd5: mAcc = mAcc + {4'h0, opnd};
      3'd6: mPc = opnd;
      default: if (mAcc == 16'h0) mPc = opnd;
    endcase
  endtask

  task automatic enterReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 reset acc", accOut, 16'h0000);
    check("R1 reset halted", {15'h0, halted}, 16'h0000);
  endtask

  task automatic runProg(input string tag, input int maxCycles);
    int tail;
    tail = 0;
    @(negedge clk);
    rstN = 1'b1;
    mPc = '0; mAcc = '0; mHalt = 1'b0;
    for (int cyc = 1; cyc <= maxCycles; cyc++) begin
      @(negedge clk);
      if ((cyc % 3) == 0 && !mHalt) modelStep();
      check({tag, " acc"}, accOut, mAcc);
      check({tag, " R8 halted"}, {15'h0, halted}, {15'h0, mHalt});
      if (mHalt) begin
        tail++;
        if (tail > 12) break;
      end
    end
    check({tag, " R8 reached halt"}, {15'h0, mHalt}, 16'h0001);
  endtask

  initial begin
    #(20 * 150000);
    nFail++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [15:0] rd;

    // Program 1: R11 summation with R6 wrap, R4 load, R5 store
    enterReset();
    bdWrite(0, enc(1, 12'h100));
    bdWrite(1, enc(4, 12'h101));
    bdWrite(2, enc(4, 12'h102));
    bdWrite(3, enc(3, 12'h103));
    bdWrite(4, enc(0, 0));
    bdWrite(12'h100, 16'hFFF0);
    bdWrite(12'h101, 16'h0020);
    bdWrite(12'h102, 16'h0003);
    bdWrite(12'h103, 16'h1111);
    runProg("R11 R6 R3", 60);
    bdRead(12'h103, rd);
    check("R11 R5 sum stored", rd, 16'h0013);
    bdRead(12'h100, rd);
    check("R10 backdoor readback", rd, 16'hFFF0);
    check("R6 final acc wrap", accOut, 16'h0013);

    // Program 2: R7 branches, R2 spare bit ignored, R6 constant add
    enterReset();
    bdWrite(0, enc(1, 12'h300));
    bdWrite(1, enc(7, 5));
    bdWrite(2, 16'h8000 | enc(5, 1));
    bdWrite(3, enc(6, 1));
    bdWrite(4, enc(0, 0));
    bdWrite(5, enc(3, 12'h301));
    bdWrite(6, enc(2, 12'hABC));
    bdWrite(7, enc(0, 0));
    bdWrite(12'h300, 16'hFFFD);
    bdWrite(12'h301, 16'h7777);
    runProg("R7 R2 R4", 300);
    check("R4 load constant", accOut, 16'h0ABC);
    bdRead(12'h301, rd);
    check("R7 zero branch store", rd, 16'h0000);

    // Program 3: R9 self-modifying code
    enterReset();
    bdWrite(0, enc(1, 12'h200));
    bdWrite(1, enc(3, 2));
    bdWrite(2, enc(0, 0));
    bdWrite(3, enc(5, 12'h0F0));
    bdWrite(4, enc(0, 0));
    bdWrite(12'h200, enc(2, 12'h055));
    runProg("R9", 120);
    check("R9 patched instruction ran", accOut, 16'h0145);
    bdRead(2, rd);
    check("R9 patched word", rd, enc(2, 12'h055));

    // Program 4: R8 nothing after halt takes effect
    enterReset();
    bdWrite(0, enc(2, 7));
    bdWrite(1, enc(0, 0));
    bdWrite(2, enc(3, 12'h310));
    bdWrite(3, enc(2, 1));
    bdWrite(12'h310, 16'h5A5A);
    runProg("R8", 60);
    check("R8 acc held after halt", accOut, 16'h0007);
    bdRead(12'h310, rd);
    check("R8 no store after halt", rd, 16'h5A5A);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule